// File: doc/BRIEF.md
# Disk Controller Programmed-I/O Command and Status Front End

This block sits between a processor's programmed-I/O bus and the sequencing logic of a moving-head disk controller. Each bus cycle arrives as a one-cycle strobe with an operation class, a 4-bit function code and a data word. There are four operation classes: output control pulse (OCP), skip test (SKS), input to accumulator (INA) and output from accumulator (OTA). The block answers in the same cycle with a skip flag, a bad-function flag and a read-data word. It updates its registers on the next clock edge.

The block keeps a status register that holds busy, ready and individual error bits, plus a one-word buffer that both directions share. A transfer or positioning command opens a handoff in which the controller asks for two control words. Each word is taken by an OTA cycle and passed on as a one-cycle pulse. Once the second word is taken, busy is set. A done input then clears busy and raises an interrupt request. Other functions select DMA or I/O-bus transfer mode, snapshot status into the buffer, stop a transfer, acknowledge the interrupt, and test the seek activity of each of eight drives one at a time.

The control-word and channel-request outputs are plain one-cycle pulses and have no back-pressure. The downstream logic must take them in the cycle they are high. The bus side has no stall either: every strobed cycle is answered at once.

Top module: `disk_pio_front`

## Requirements
- R1: After reset, busy, ready, interrupt request, DMA mode, transfer-done flag, all error bits and the buffer are zero, and the handoff stage is idle.
- R2: A strobed cycle raises io_badfnc, has no skip, returns io_wdata and changes no state in these cases: OCP with function 11 to 15; SKS with function 5, 6 or 8; INA or OTA with a nonzero function.
- R3: OCP functions 0 to 5 are commands. When not busy, a command opens the handoff at control word 1, sets ready, clears all error bits and the transfer-done flag, and pulses cmd_start with cmd_fnc one cycle later. While busy, a command is ignored.
- R4: An OTA taken in stage 1 pulses cw_valid one cycle later with cw_sel=0 and the data, moves to stage 2 and sets ready again. An OTA taken in stage 2 pulses cw_valid with cw_sel=1, returns to idle and sets busy.
- R5: OCP function 6 (stop) clears busy and returns the handoff to idle. It pulses xfer_abort one cycle later if busy was set.
- R6: OCP function 7 (read status) is ignored while busy. Otherwise it sets ready and loads the buffer with: bit 1 = 1, bit 0 = 0, bits 5:2 = the error bits, bit 15 = the OR of the error bits, and all other bits 0.
- R7: OCP function 8 selects DMA mode and function 9 selects I/O-bus mode. A read status that is accepted in DMA mode pulses chan_req one cycle later.
- R8: INA with function 0 and ready set returns io_wdata OR buffer, skips and clears ready. With ready clear it returns io_wdata and does not skip.
- R9: OTA with function 0 and ready set skips, stores the data in the buffer and clears ready. With ready clear it neither skips nor changes state.
- R10: SKS skips on these tests: function 0 if ready; 1 if no interrupt is pending; 2 if neither busy nor any error bit is set; 3 if no error bit is set; 4 if not busy.
- R11: SKS function 7 skips if drive 7 is not seeking. Functions 9 to 15 skip if drives 0 to 6 are not seeking.
- R12: An eor_strobe pulse sets eor_flag, which holds until the next accepted command.
- R13: A xfer_done pulse while busy (without a stop in the same cycle) clears busy and sets int_req. OCP function 10 clears int_req. Each err_set bit sets the matching error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Bus cycle strobe |
| io_op | input | 2 | Operation class: 0 OCP, 1 SKS, 2 INA, 3 OTA |
| io_fnc | input | 4 | Function code |
| io_wdata | input | 16 | Data from the processor |
| io_rdata | output | 16 | Data returned to the processor |
| io_skip | output | 1 | Skip response |
| io_badfnc | output | 1 | Unsupported function for this operation class |
| drv_seeking | input | 8 | Per-drive seek-in-progress flags |
| xfer_done | input | 1 | Transfer completion pulse |
| err_set | input | 4 | Pulses that set individual error bits |
| eor_strobe | input | 1 | End-of-range pulse from the DMA channel |
| busy | output | 1 | Transfer in progress |
| int_req | output | 1 | Interrupt request |
| dma_mode | output | 1 | 1 = DMA transfer mode, 0 = I/O-bus mode |
| eor_flag | output | 1 | Transfer-done flag from end of range |
| chan_req | output | 1 | DMA channel request pulse |
| cmd_start | output | 1 | Command accepted pulse |
| cmd_fnc | output | 4 | Function code of the accepted command |
| cw_valid | output | 1 | Control word handoff pulse |
| cw_sel | output | 1 | 0 = control word 1, 1 = control word 2 |
| cw_data | output | 16 | Handed-off control word |
| xfer_abort | output | 1 | Active transfer aborted pulse |

## Verification
The bench builds the block with its default 16-bit data word and four error bits. This places the summary bit at bit 15 and the error field at bits 5:2, so a read-status snapshot that is returned through INA shows the summary and individual error bits at the same time as a caller OR pattern. With eight drives, every drive-test code, including the out-of-order one for drive 7, can be walked against a seek pattern that has both set and clear bits. The command, handoff, stop, completion and acknowledge sequences are run from idle, from mid-handoff and from busy.

// File: rtl/disk_pio_pkg.sv
package disk_pio_pkg;
  typedef enum logic [1:0] {
    OP_OCP = 2'd0,
    OP_SKS = 2'd1,
    OP_INA = 2'd2,
    OP_OTA = 2'd3
  } io_op_e;

  typedef enum logic [1:0] {
    CW_IDLE = 2'd0,
    CW_ONE  = 2'd1,
    CW_TWO  = 2'd2
  } cw_stage_e;

  localparam int NUM_DRIVES = 8;
  localparam logic [3:0] FN_LAST_CMD = 4'd5;
  localparam logic [3:0] FN_STOP     = 4'd6;
  localparam logic [3:0] FN_RDSTAT   = 4'd7;
  localparam logic [3:0] FN_SEL_DMA  = 4'd8;
  localparam logic [3:0] FN_SEL_BUS  = 4'd9;
  localparam logic [3:0] FN_ACK_INT  = 4'd10;

  typedef struct packed {
    logic cmd;
    logic stop;
    logic rdstat;
    logic sel_dma;
    logic sel_bus;
    logic ackint;
    logic ina;
    logic ota;
    logic sks;
    logic bad;
  } dec_t;

  function automatic logic [3:0] drive_test_code(input int drv);
    return (drv == NUM_DRIVES - 1) ? 4'd7 : 4'(9 + drv);
  endfunction
endpackage

// File: rtl/pio_fn_decode.sv
module pio_fn_decode
  import disk_pio_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op,
  input  logic [3:0] fnc,
  output dec_t       dec
);
  always_comb begin
    dec = '0;
    if (valid) begin
      unique case (io_op_e'(op))
        OP_OCP: begin
          if (fnc <= FN_LAST_CMD) dec.cmd = 1'b1;
          else if (fnc == FN_STOP) dec.stop = 1'b1;
          else if (fnc == FN_RDSTAT) dec.rdstat = 1'b1;
          else if (fnc == FN_SEL_DMA) dec.sel_dma = 1'b1;
          else if (fnc == FN_SEL_BUS) dec.sel_bus = 1'b1;
          else if (fnc == FN_ACK_INT) dec.ackint = 1'b1;
          else dec.bad = 1'b1;
        end
        OP_SKS: begin
          if (fnc == 4'd5 || fnc == 4'd6 || fnc == 4'd8) dec.bad = 1'b1;
          else dec.sks = 1'b1;
        end
        OP_INA: begin
          if (fnc != 4'd0) dec.bad = 1'b1;
          else dec.ina = 1'b1;
        end
        OP_OTA: begin
          if (fnc != 4'd0) dec.bad = 1'b1;
          else dec.ota = 1'b1;
        end
        default: dec.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pio_cw_seq.sv
module pio_cw_seq
  import disk_pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              take,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  output cw_stage_e         stage,
  output logic              busy,
  output logic              cw_valid,
  output logic              cw_sel,
  output logic [DATA_W-1:0] cw_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= CW_IDLE;
      busy     <= 1'b0;
      cw_valid <= 1'b0;
      cw_sel   <= 1'b0;
      cw_data  <= '0;
    end else begin
      cw_valid <= 1'b0;
      if (stop) begin
        stage <= CW_IDLE;
        busy  <= 1'b0;
      end else if (start) begin
        stage <= CW_ONE;
      end else if (take && stage == CW_ONE) begin
        stage    <= CW_TWO;
        cw_valid <= 1'b1;
        cw_sel   <= 1'b0;
        cw_data  <= data;
      end else if (take && stage == CW_TWO) begin
        stage    <= CW_IDLE;
        busy     <= 1'b1;
        cw_valid <= 1'b1;
        cw_sel   <= 1'b1;
        cw_data  <= data;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  assert_busy_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> stage == CW_IDLE);
  assert_second_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_sel) |-> busy);
endmodule

// File: rtl/disk_pio_front.sv
module disk_pio_front
  import disk_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic [1:0]        io_op,
  input  logic [3:0]        io_fnc,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_skip,
  output logic              io_badfnc,
  input  logic [7:0]        drv_seeking,
  input  logic              xfer_done,
  input  logic [ERR_W-1:0]  err_set,
  input  logic              eor_strobe,
  output logic              busy,
  output logic              int_req,
  output logic              dma_mode,
  output logic              eor_flag,
  output logic              chan_req,
  output logic              cmd_start,
  output logic [3:0]        cmd_fnc,
  output logic              cw_valid,
  output logic              cw_sel,
  output logic [DATA_W-1:0] cw_data,
  output logic              xfer_abort
);
  localparam int SUM_BIT = DATA_W - 1;
  localparam int ERR_LSB = 2;

  dec_t        dec;
  cw_stage_e   stage;
  logic        ready_q;
  logic [ERR_W-1:0]  err_q;
  logic [DATA_W-1:0] buf_q;
  logic        any_err, cmd_go, rdstat_go, ota_take, done_hit, sks_hit;
  logic [NUM_DRIVES-1:0] drv_hit;
  logic [DATA_W-1:0] snap;

  pio_fn_decode u_dec (
    .valid(io_valid), .op(io_op), .fnc(io_fnc), .dec(dec)
  );

  assign any_err   = |err_q;
  assign cmd_go    = dec.cmd && !busy;
  assign rdstat_go = dec.rdstat && !busy;
  assign ota_take  = dec.ota && ready_q;
  assign done_hit  = xfer_done && busy && !dec.stop;

  pio_cw_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_go), .stop(dec.stop),
    .take(ota_take), .done(xfer_done), .data(io_wdata),
    .stage(stage), .busy(busy), .cw_valid(cw_valid),
    .cw_sel(cw_sel), .cw_data(cw_data)
  );

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    assign drv_hit[g] = (io_fnc == drive_test_code(g)) && !drv_seeking[g];
  end

  always_comb begin
    unique case (io_fnc)
      4'd0:    sks_hit = ready_q;
      4'd1:    sks_hit = !int_req;
      4'd2:    sks_hit = !(busy || any_err);
      4'd3:    sks_hit = !any_err;
      4'd4:    sks_hit = !busy;
      default: sks_hit = |drv_hit;
    endcase
  end

  always_comb begin
    snap = '0;
    snap[1] = 1'b1;
    snap[ERR_LSB +: ERR_W] = err_q;
    snap[SUM_BIT] = any_err;
  end

  assign io_badfnc = dec.bad;
  assign io_skip   = (dec.sks && sks_hit) || ((dec.ina || dec.ota) && ready_q);
  assign io_rdata  = io_wdata | ((dec.ina && ready_q) ? buf_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      err_q      <= '0;
      buf_q      <= '0;
      int_req    <= 1'b0;
      dma_mode   <= 1'b0;
      eor_flag   <= 1'b0;
      chan_req   <= 1'b0;
      cmd_start  <= 1'b0;
      cmd_fnc    <= '0;
      xfer_abort <= 1'b0;
    end else begin
      if (rdstat_go || cmd_go || (ota_take && stage == CW_ONE))
        ready_q <= 1'b1;
      else if ((dec.ina || dec.ota) && ready_q)
        ready_q <= 1'b0;
      err_q <= (cmd_go ? '0 : err_q) | err_set;
      if (ota_take) buf_q <= io_wdata;
      else if (rdstat_go) buf_q <= snap;
      int_req  <= (int_req && !dec.ackint) || done_hit;
      if (dec.sel_dma) dma_mode <= 1'b1;
      else if (dec.sel_bus) dma_mode <= 1'b0;
      eor_flag   <= (eor_flag && !cmd_go) || eor_strobe;
      chan_req   <= rdstat_go && dma_mode;
      cmd_start  <= cmd_go;
      if (cmd_go) cmd_fnc <= io_fnc;
      xfer_abort <= dec.stop && busy;
    end
  end

  assert_skip_not_bad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_skip && io_badfnc));
  assert_abort_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> !busy);
  assert_chanreq_dma_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_req |-> $past(dma_mode));
  assert_cw_from_ota_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> $past(io_valid && io_op == 2'd3));
  assert_int_from_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> $past(xfer_done));
  assert_start_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !$past(busy));
endmodule

// File: tb/disk_pio_front_tb_top.sv
`timescale 1ns/100ps
module disk_pio_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic [1:0]  io_op = 2'd0;
  logic [3:0]  io_fnc = 4'd0;
  logic [15:0] io_wdata = 16'd0;
  logic [15:0] io_rdata;
  logic        io_skip, io_badfnc;
  logic [7:0]  drv_seeking = 8'd0;
  logic        xfer_done = 1'b0;
  logic [3:0]  err_set = 4'd0;
  logic        eor_strobe = 1'b0;
  logic        busy, int_req, dma_mode, eor_flag, chan_req, cmd_start;
  logic [3:0]  cmd_fnc;
  logic        cw_valid, cw_sel, xfer_abort;
  logic [15:0] cw_data;

  always #2.5 clk = ~clk;

  disk_pio_front dut_i (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_op(io_op),
    .io_fnc(io_fnc), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_skip(io_skip), .io_badfnc(io_badfnc), .drv_seeking(drv_seeking),
    .xfer_done(xfer_done), .err_set(err_set), .eor_strobe(eor_strobe),
    .busy(busy), .int_req(int_req), .dma_mode(dma_mode),
    .eor_flag(eor_flag), .chan_req(chan_req), .cmd_start(cmd_start),
    .cmd_fnc(cmd_fnc), .cw_valid(cw_valid), .cw_sel(cw_sel),
    .cw_data(cw_data), .xfer_abort(xfer_abort)
  );

  int checks = 0;
  int failures = 0;

  // reference model state
  bit m_busy, m_ready, m_int, m_dma, m_eor;
  int m_stage;
  logic [3:0]  m_err;
  logic [15:0] m_buf;
  bit e_cwv, e_cws, e_chr, e_cms, e_abt;
  logic [15:0] e_cwd;
  logic [3:0]  e_cmf;
  // sideband requests for the next cycle
  logic [3:0] s_err;
  bit s_eor, s_done;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int op, input int fn, input logic [15:0] d);
    bit bad, skip, stop, take;
    logic [15:0] rd;
    int drv;
    bit n_busy, n_ready, n_int, n_dma, n_eor;
    int n_stage;
    logic [3:0] n_err;
    logic [15:0] n_buf;
    @(negedge clk);
    io_valid = v; io_op = 2'(op); io_fnc = 4'(fn); io_wdata = d;
    err_set = s_err; eor_strobe = s_eor; xfer_done = s_done;
    #1;
    bad = 0; skip = 0; stop = 0; take = 0; rd = d;
    n_busy = m_busy; n_ready = m_ready; n_int = m_int; n_dma = m_dma;
    n_eor = m_eor; n_stage = m_stage; n_err = m_err; n_buf = m_buf;
    if (v) begin
      if (op == 0) begin
        if (fn > 10) bad = 1;
        else if (fn <= 5) begin
          if (!m_busy) begin n_stage = 1; n_ready = 1; n_err = 0; n_eor = 0; end
        end else if (fn == 6) begin stop = 1; n_busy = 0; n_stage = 0; end
        else if (fn == 7) begin
          if (!m_busy) begin
            n_ready = 1;
            n_buf = {(m_err != 0), 9'd0, m_err, 2'b10};
          end
        end else if (fn == 8) n_dma = 1;
        else if (fn == 9) n_dma = 0;
        else n_int = 0;
      end else if (op == 1) begin
        if (fn == 5 || fn == 6 || fn == 8) bad = 1;
        else if (fn == 0) skip = m_ready;
        else if (fn == 1) skip = !m_int;
        else if (fn == 2) skip = !m_busy && m_err == 0;
        else if (fn == 3) skip = m_err == 0;
        else if (fn == 4) skip = !m_busy;
        else begin
          drv = (fn == 7) ? 7 : fn - 9;
          skip = !drv_seeking[drv];
        end
      end else if (op == 2) begin
        if (fn != 0) bad = 1;
        else if (m_ready) begin skip = 1; rd = d | m_buf; n_ready = 0; end
      end else begin
        if (fn != 0) bad = 1;
        else if (m_ready) begin
          skip = 1; take = 1; n_ready = 0; n_buf = d;
          if (m_stage == 1) begin n_stage = 2; n_ready = 1; end
          else if (m_stage == 2) begin n_stage = 0; n_busy = 1; end
        end
      end
    end
    if (s_done && m_busy && !stop) begin n_busy = 0; n_int = 1; end
    n_err = n_err | s_err;
    if (s_eor) n_eor = 1;
    // compare
    chk("R2", "io_badfnc", io_badfnc, bad);
    chk(op == 1 ? "R10/R11" : "R8/R9", "io_skip", io_skip, skip);
    chk("R8", "io_rdata", io_rdata, rd);
    chk("R4", "busy", busy, m_busy);
    chk("R13", "int_req", int_req, m_int);
    chk("R7", "dma_mode", dma_mode, m_dma);
    chk("R12", "eor_flag", eor_flag, m_eor);
    chk("R4", "cw_valid", cw_valid, e_cwv);
    if (e_cwv) begin
      chk("R4", "cw_sel", cw_sel, e_cws);
      chk("R4", "cw_data", cw_data, e_cwd);
    end
    chk("R7", "chan_req", chan_req, e_chr);
    chk("R3", "cmd_start", cmd_start, e_cms);
    if (e_cms) chk("R3", "cmd_fnc", cmd_fnc, e_cmf);
    chk("R5", "xfer_abort", xfer_abort, e_abt);
    // pulse expectations for the following cycle
    e_cwv = take && m_stage != 0;
    e_cws = (m_stage == 2);
    e_cwd = d;
    e_chr = v && op == 0 && fn == 7 && !m_busy && m_dma;
    e_cms = v && op == 0 && fn <= 5 && !m_busy;
    e_cmf = 4'(fn);
    e_abt = stop && m_busy;
    @(posedge clk);
    m_busy = n_busy; m_ready = n_ready; m_int = n_int; m_dma = n_dma;
    m_eor = n_eor; m_stage = n_stage; m_err = n_err; m_buf = n_buf;
    s_err = 0; s_eor = 0; s_done = 0;
  endtask

  initial begin
    #20000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_busy = 0; m_ready = 0; m_int = 0; m_dma = 0; m_eor = 0; m_stage = 0;
    m_err = 0; m_buf = 0; e_cwv = 0; e_cws = 0; e_cwd = 0; e_chr = 0;
    e_cms = 0; e_cmf = 0; e_abt = 0; s_err = 0; s_eor = 0; s_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state visible through ports and skip tests
    cyc(0, 0, 0, 16'h0000);
    cyc(1, 1, 0, 16'h0000);  // R10 not ready
    cyc(1, 2, 0, 16'h1111);  // R8 INA not ready: no skip, buffer empty
    for (int f = 1; f <= 4; f++) cyc(1, 1, f, 16'h0000);  // R10
    // R2: bad function codes
    cyc(1, 0, 12, 16'h00F0); cyc(1, 0, 15, 16'h0000);
    cyc(1, 1, 5, 16'h0000); cyc(1, 1, 6, 16'h0000); cyc(1, 1, 8, 16'h0000);
    cyc(1, 2, 1, 16'h0003); cyc(1, 3, 2, 16'h0004);
    // R13: error inputs; R10 tests see them
    s_err = 4'b0010; cyc(0, 0, 0, 16'h0000);
    cyc(1, 1, 3, 16'h0000); cyc(1, 1, 2, 16'h0000);
    // R7/R6: DMA mode, read status, INA returns snapshot
    cyc(1, 0, 8, 16'h0000);
    cyc(1, 0, 7, 16'h0000);
    cyc(1, 1, 0, 16'h0000);
    cyc(1, 2, 0, 16'h0100);  // R6 R8 expect 0x810A
    cyc(1, 2, 0, 16'h0100);  // ready cleared
    cyc(1, 0, 9, 16'h0000);
    cyc(1, 0, 7, 16'h0000);  // no chan_req in I/O-bus mode
    // R9: OTA stores into buffer while idle
    cyc(1, 3, 0, 16'h1234);
    cyc(1, 3, 0, 16'h4321);  // not ready: ignored
    cyc(1, 0, 7, 16'h0000); cyc(1, 2, 0, 16'h0000);
    // R12 then R3: command clears errors and eor flag
    s_eor = 1; cyc(0, 0, 0, 16'h0000);
    cyc(1, 0, 3, 16'h0000);
    cyc(1, 1, 3, 16'h0000);
    cyc(1, 3, 0, 16'hAAAA);  // R4 word 1
    cyc(1, 3, 0, 16'h5555);  // R4 word 2 -> busy
    cyc(1, 1, 4, 16'h0000);
    cyc(1, 0, 7, 16'h0000);  // R6 ignored while busy
    cyc(1, 1, 0, 16'h0000);
    cyc(1, 0, 2, 16'h0000);  // R3 ignored while busy
    s_eor = 1; cyc(0, 0, 0, 16'h0000);
    s_done = 1; cyc(0, 0, 0, 16'h0000);  // R13
    cyc(1, 1, 1, 16'h0000);
    cyc(1, 0, 10, 16'h0000); cyc(1, 1, 1, 16'h0000);
    // R5: stop mid-handoff, then OTA only fills buffer
    cyc(1, 0, 0, 16'h0000); cyc(1, 3, 0, 16'h0F0F);
    cyc(1, 0, 6, 16'h0000); cyc(1, 3, 0, 16'hF0F0);
    cyc(1, 0, 7, 16'h0000); cyc(1, 2, 0, 16'h0000);
    // R5: stop while busy aborts; done after stop has no effect
    cyc(1, 0, 5, 16'h0000); cyc(1, 3, 0, 16'h0001); cyc(1, 3, 0, 16'h0002);
    s_done = 1; cyc(1, 0, 6, 16'h0000);
    cyc(0, 0, 0, 16'h0000); cyc(1, 1, 4, 16'h0000);
    // R11: drive seek tests
    drv_seeking = 8'b1000_0101;
    cyc(1, 1, 7, 16'h0000);
    for (int f = 9; f <= 15; f++) cyc(1, 1, f, 16'h0000);
    drv_seeking = 8'b0111_1010;
    cyc(1, 1, 7, 16'h0000);
    for (int f = 9; f <= 15; f++) cyc(1, 1, f, 16'h0000);
    cyc(0, 0, 0, 16'h0000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule